// File: doc/BRIEF.md
# Encoder Speed Sampling Unit

This block turns a running encoder position count into the raw ingredients of a speed value: a count change and the time over which that change was seen. It watches a position count together with a one-cycle strobe that marks every count update. At the end of each sample window it issues a one-cycle valid pulse with a registered count delta and a registered elapsed time in clock cycles. A downstream divider turns the pair into engineering units.

Two sampling methods are available, selected by a mode bit. With the bit clear, the block takes the count difference over a fixed window. With the bit set, each measurement ends on the last count update inside the window, and the elapsed time is the distance between timestamps of successive such updates. A 4-bit rate code picks the window length as `TICK_DIV * 2^code` clock cycles. Long windows resolve very low speeds. Short windows give fast updates for high-gain regulation. `TICK_DIV` must be at least 2.

The control is a two-state machine. `ST_PRIME` is the first cycle after reset. It captures the reference count, the reference timestamp and the configuration, then always moves to `ST_SAMPLE`. `ST_SAMPLE` holds while windows run. On every window end it stays in `ST_SAMPLE`, produces a result and latches the configuration for the next window.

Top module: `enc_speed_sampler`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `smp_valid` is 0 and `smp_delta` and `smp_elapsed` are 0.
- R2: The first window starts in the second clock cycle after reset release. Each window lasts exactly `TICK_DIV * 2^code` cycles. `smp_valid` is high for exactly one cycle, in the cycle after the last cycle of each window.
- R3: With `edge_mode` = 0, `smp_delta` equals the count at the last window cycle minus the count at the previous window end (or at priming). `smp_elapsed` equals `TICK_DIV * 2^code`.
- R4: With `edge_mode` = 1 and at least one strobe in the window, `smp_delta` equals the count captured at the last strobe minus the reference count. `smp_elapsed` equals that strobe's timestamp minus the reference timestamp. Both references then move to that strobe.
- R5: With `edge_mode` = 1 and no strobe in the window, `smp_delta` is 0. `smp_elapsed` equals the timestamp of the last window cycle minus the unchanged reference timestamp, so the elapsed time keeps growing across empty windows.
- R6: A strobe in the last cycle of a window belongs to the window that is ending.
- R7: `edge_mode` and `rate_code` are sampled only at priming and in the last cycle of each window. Changes in other cycles do not affect the window that is running.
- R8: `smp_delta` is a two's-complement difference modulo `2^CNT_W`, so reverse motion and count wrap give the signed change.
- R9: Between valid pulses, `smp_delta` and `smp_elapsed` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_count | input | CNT_W | Running encoder position count |
| cnt_upd | input | 1 | One-cycle strobe marking a count update |
| edge_mode | input | 1 | 1 selects edge-aligned sampling, 0 selects fixed-window difference |
| rate_code | input | 4 | Window length exponent: `TICK_DIV * 2^rate_code` cycles |
| smp_delta | output | CNT_W | Registered count change of the finished window |
| smp_elapsed | output | TS_W | Registered elapsed time in clock cycles |
| smp_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
A count-update strobe can land in the same cycle as a window end. The block must then fold that strobe into the ending window, and must not carry it into the next one. The bench provokes this by driving periodic strobes whose periods do not divide the window lengths, so strobes keep drifting onto window boundaries in both modes. A reference model then decides which window owns each strobe, and the delta and elapsed values of both that window and the following one show whether the strobe was attributed correctly. The same sweeps also change mode and rate in mid-window, which tests that configuration changes are sampled only at window boundaries.

// File: rtl/ess_pkg.sv
package ess_pkg;

    localparam int RATE_W = 4;

    typedef enum logic {
        ST_PRIME  = 1'b0,
        ST_SAMPLE = 1'b1
    } ess_state_t;

    typedef struct packed {
        logic              edge_mode;
        logic [RATE_W-1:0] code;
    } ess_cfg_t;

endpackage

// File: rtl/ess_window_timer.sv
module ess_window_timer #(
    parameter int TICK_DIV = 2500,
    parameter int RATE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] code,
    output logic              win_end
);
    localparam int PRE_W  = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int TCNT_W = 1 << RATE_W;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [TCNT_W-1:0] tick_q;
    logic [TCNT_W-1:0] tick_last;
    logic              tick;

    assign tick      = (pre_q == PRE_LAST);
    assign tick_last = (TCNT_W'(1) << code) - TCNT_W'(1);
    assign win_end   = run && tick && (tick_q == tick_last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            tick_q <= win_end ? '0 : tick_q + TCNT_W'(1);
        end else begin
            pre_q  <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/ess_stamp_capture.sv
module ess_stamp_capture #(
    parameter int CNT_W = 16,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_upd,
    input  logic [CNT_W-1:0] pos_count,
    input  logic             clear,
    output logic [TS_W-1:0]  ts_now,
    output logic             edge_seen,
    output logic             eff_seen,
    output logic [CNT_W-1:0] eff_cnt,
    output logic [TS_W-1:0]  eff_ts
);
    logic [CNT_W-1:0] last_cnt_q;
    logic [TS_W-1:0]  last_ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_now     <= '0;
            last_cnt_q <= '0;
            last_ts_q  <= '0;
            edge_seen  <= 1'b0;
        end else begin
            ts_now <= ts_now + TS_W'(1);
            if (cnt_upd) begin
                last_cnt_q <= pos_count;
                last_ts_q  <= ts_now;
            end
            edge_seen <= clear ? 1'b0 : (edge_seen | cnt_upd);
        end
    end

    // a strobe in the current cycle overrides the stored capture
    assign eff_seen = edge_seen | cnt_upd;
    assign eff_cnt  = cnt_upd ? pos_count : last_cnt_q;
    assign eff_ts   = cnt_upd ? ts_now    : last_ts_q;

endmodule

// File: rtl/ess_fsm.sv
module ess_fsm
    import ess_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TS_W     = 32,
    parameter int TICK_DIV = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end,
    input  ess_cfg_t         cfg_in,
    input  logic [CNT_W-1:0] pos_count,
    input  logic [TS_W-1:0]  ts_now,
    input  logic             eff_seen,
    input  logic [CNT_W-1:0] eff_cnt,
    input  logic [TS_W-1:0]  eff_ts,
    output ess_state_t       state,
    output ess_cfg_t         cfg_q,
    output logic [CNT_W-1:0] delta_q,
    output logic [TS_W-1:0]  elapsed_q,
    output logic             valid_q
);
    localparam logic [TS_W-1:0] BASE = TS_W'(TICK_DIV);

    logic [CNT_W-1:0] ref_cnt_q;
    logic [TS_W-1:0]  ref_ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= ST_SAMPLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            ref_cnt_q <= '0;
            ref_ts_q  <= '0;
            delta_q   <= '0;
            elapsed_q <= '0;
            valid_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_PRIME: begin
                    cfg_q     <= cfg_in;
                    ref_cnt_q <= pos_count;
                    ref_ts_q  <= ts_now;
                    valid_q   <= 1'b0;
                end
                ST_SAMPLE: begin
                    valid_q <= win_end;
                    if (win_end) begin
                        cfg_q <= cfg_in;
                        if (!cfg_q.edge_mode) begin
                            delta_q   <= pos_count - ref_cnt_q;
                            elapsed_q <= BASE << cfg_q.code;
                            ref_cnt_q <= pos_count;
                            ref_ts_q  <= ts_now;
                        end else if (eff_seen) begin
                            delta_q   <= eff_cnt - ref_cnt_q;
                            elapsed_q <= eff_ts - ref_ts_q;
                            ref_cnt_q <= eff_cnt;
                            ref_ts_q  <= eff_ts;
                        end else begin
                            delta_q   <= '0;
                            elapsed_q <= ts_now - ref_ts_q;
                        end
                    end
                end
                default: valid_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/enc_speed_sampler.sv
module enc_speed_sampler
    import ess_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TS_W     = 32,
    parameter int TICK_DIV = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  pos_count,
    input  logic              cnt_upd,
    input  logic              edge_mode,
    input  logic [RATE_W-1:0] rate_code,
    output logic [CNT_W-1:0]  smp_delta,
    output logic [TS_W-1:0]   smp_elapsed,
    output logic              smp_valid
);
    ess_state_t       state;
    ess_cfg_t         cfg_in;
    ess_cfg_t         cfg_q;
    logic             win_end;
    logic             run;
    logic [TS_W-1:0]  ts_now;
    logic             edge_seen;
    logic             eff_seen;
    logic [CNT_W-1:0] eff_cnt;
    logic [TS_W-1:0]  eff_ts;

    assign cfg_in.edge_mode = edge_mode;
    assign cfg_in.code      = rate_code;
    assign run              = (state == ST_SAMPLE);

    ess_window_timer #(.TICK_DIV(TICK_DIV), .RATE_W(RATE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .code    (cfg_q.code),
        .win_end (win_end)
    );

    ess_stamp_capture #(.CNT_W(CNT_W), .TS_W(TS_W)) u_stamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_upd   (cnt_upd),
        .pos_count (pos_count),
        .clear     (win_end || !run),
        .ts_now    (ts_now),
        .edge_seen (edge_seen),
        .eff_seen  (eff_seen),
        .eff_cnt   (eff_cnt),
        .eff_ts    (eff_ts)
    );

    ess_fsm #(.CNT_W(CNT_W), .TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end   (win_end),
        .cfg_in    (cfg_in),
        .pos_count (pos_count),
        .ts_now    (ts_now),
        .eff_seen  (eff_seen),
        .eff_cnt   (eff_cnt),
        .eff_ts    (eff_ts),
        .state     (state),
        .cfg_q     (cfg_q),
        .delta_q   (smp_delta),
        .elapsed_q (smp_elapsed),
        .valid_q   (smp_valid)
    );

endmodule

// File: rtl/ess_checker.sv
module ess_checker #(
    parameter int CNT_W    = 16,
    parameter int TS_W     = 32,
    parameter int TICK_DIV = 2500
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [CNT_W-1:0] smp_delta,
    input logic [TS_W-1:0]  smp_elapsed,
    input logic             win_end,
    input logic             cnt_upd,
    input logic             edge_seen,
    input logic             cfg_edge,
    input logic [3:0]       cfg_code
);
    // R2: result pulse lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R2: every window end yields a result in the next cycle
    a_r2_end_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> smp_valid);

    // R3: fixed-window elapsed time equals the window length
    a_r3_fixed_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !$past(cfg_edge)) |->
            (smp_elapsed == (TS_W'(TICK_DIV) << $past(cfg_code))));

    // R5: empty edge-aligned window reports zero motion
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && $past(cfg_edge) && !$past(edge_seen) && !$past(cnt_upd)) |->
            (smp_delta == '0));

    // R9: results hold between pulses
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ($stable(smp_delta) && $stable(smp_elapsed)));

endmodule

bind enc_speed_sampler ess_checker #(
    .CNT_W(CNT_W), .TS_W(TS_W), .TICK_DIV(TICK_DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_delta   (smp_delta),
    .smp_elapsed (smp_elapsed),
    .win_end     (win_end),
    .cnt_upd     (cnt_upd),
    .edge_seen   (edge_seen),
    .cfg_edge    (cfg_q.edge_mode),
    .cfg_code    (cfg_q.code)
);

// File: tb/tb_enc_speed_sampler.sv
module tb_enc_speed_sampler;
    localparam int CNT_W    = 12;
    localparam int TS_W     = 20;
    localparam int TICK_DIV = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] pos_count;
    logic             cnt_upd;
    logic             edge_mode;
    logic [3:0]       rate_code;
    logic [CNT_W-1:0] smp_delta;
    logic [TS_W-1:0]  smp_elapsed;
    logic             smp_valid;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    enc_speed_sampler #(.CNT_W(CNT_W), .TS_W(TS_W), .TICK_DIV(TICK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .pos_count(pos_count), .cnt_upd(cnt_upd),
        .edge_mode(edge_mode), .rate_code(rate_code),
        .smp_delta(smp_delta), .smp_elapsed(smp_elapsed), .smp_valid(smp_valid)
    );

    // reference model, evaluated from the requirements
    logic [TS_W-1:0]  m_ts;
    logic [CNT_W-1:0] rc, lc, ed;
    logic [TS_W-1:0]  rt, lt, ee;
    logic             mc, sn, primed, ev, chg, endw;
    logic [3:0]       kc;
    int               wc;
    string            etag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ts = '0; primed = 1'b0; ev = 1'b0; ed = '0; ee = '0;
            etag = "R1";
        end else begin
            ev = 1'b0;
            if (!primed) begin
                rc = pos_count; rt = m_ts; mc = edge_mode; kc = rate_code;
                wc = 0; sn = 1'b0; chg = 1'b0; primed = 1'b1;
            end else begin
                endw = (wc == (TICK_DIV << kc) - 1);
                if (!endw && (edge_mode != mc || rate_code != kc)) chg = 1'b1;
                if (cnt_upd) begin lc = pos_count; lt = m_ts; sn = 1'b1; end
                if (endw) begin
                    ev = 1'b1;
                    if (!mc) begin
                        ed = pos_count - rc; ee = TS_W'(TICK_DIV) << kc;
                        rc = pos_count; rt = m_ts; etag = "R3";
                    end else if (sn) begin
                        ed = lc - rc; ee = lt - rt; rc = lc; rt = lt;
                        etag = cnt_upd ? "R6" : "R4";
                    end else begin
                        ed = '0; ee = m_ts - rt; etag = "R5";
                    end
                    if (chg) etag = "R7";
                    sn = 1'b0; chg = 1'b0; mc = edge_mode; kc = rate_code; wc = 0;
                end else begin
                    wc++;
                end
            end
            m_ts = m_ts + TS_W'(1);
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && primed) begin
            if (smp_valid || ev) check("R2 valid", longint'(smp_valid), longint'(ev));
            if (ev) begin
                check(ed[CNT_W-1] ? "R8 delta" : {etag, " delta"},
                      longint'(smp_delta), longint'(ed));
                check({etag, " elapsed"}, longint'(smp_elapsed), longint'(ee));
            end else begin
                check("R9 hold", longint'({smp_delta, smp_elapsed}), longint'({ed, ee}));
            end
        end
        if (cyc > 150000) begin
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic run_phase(input logic m, input logic [3:0] c, input int period,
                             input logic [CNT_W-1:0] step, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            edge_mode = m;
            rate_code = c;
            if (period != 0 && (i % period) == period - 1) begin
                pos_count = pos_count + step;
                cnt_upd   = 1'b1;
            end else begin
                cnt_upd   = 1'b0;
            end
        end
    endtask

    initial begin
        int periods[4];
        logic [CNT_W-1:0] steps[4];
        periods = '{3, 5, 0, 7};
        steps   = '{12'd1, 12'hFFF, 12'd0, 12'd3};
        rst_n = 1'b0; pos_count = 12'hFF0; cnt_upd = 1'b0; edge_mode = 1'b0; rate_code = 4'd0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 valid",   longint'(smp_valid),   0);
        check("R1 delta",   longint'(smp_delta),   0);
        check("R1 elapsed", longint'(smp_elapsed), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-release valid", longint'(smp_valid), 0);
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 6; c++)
                for (int p = 0; p < 4; p++)
                    run_phase(m[0], 4'(c), periods[p], steps[p], 4 * (TICK_DIV << c) + 3);
        // long standstill in edge mode, then motion resumes
        run_phase(1'b1, 4'd1, 0, 12'd0, 60);
        run_phase(1'b1, 4'd1, 11, 12'hFFE, 80);
        run_phase(1'b0, 4'd8, 13, 12'd2, 2 * (TICK_DIV << 8) + 5);
        run_phase(1'b1, 4'd2, 8, 12'd1, 64);
        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule